// File: doc/BRIEF.md
# Serial PHY Control-Port Handshake Master

This block lets a host reach the internal registers of a serial PHY through a narrow control port. The host hands over one command at a time on a valid/ready port: an address capture, a data write or a data read, each carrying a 16-bit value. The engine drives the value onto the PHY's 16-bit data-in bus. It then walks the PHY's four strobes (address capture, data capture, write, read) through four-phase request/acknowledge handshakes against a single acknowledge input. For a read, it returns the word found on the PHY's data-out bus.

Every wait for an acknowledge level is a bounded poll. The acknowledge is sampled at a fixed interval derived from the clock frequency, for a limited number of samples. If the level never arrives, the command ends with an error. The strobe is left where it was, and a sticky error flag is raised. A write whose value has bit 0 set puts the PHY into reset, so the PHY cannot answer. That write raises its write strobe and completes at once.

States: IDLE (waiting for a command), SETUP (data-in loaded, strobes cleared), ADDR_HI/ADDR_LO, DCAP_HI/DCAP_LO, WR_HI/WR_LO, RD_HI/RD_LO (strobe raised and waiting for acknowledge high / strobe lowered and waiting for acknowledge low), and DONE (one-cycle completion). Transitions: IDLE→SETUP when a command is taken. SETUP→ADDR_HI, DCAP_HI or RD_HI by opcode. Each *_HI→*_LO on acknowledge high. ADDR_LO, WR_LO and RD_LO→DONE on acknowledge low. DCAP_LO→WR_HI on acknowledge low, or DCAP_LO→DONE when data bit 0 is set. Any wait state→DONE on timeout. DONE→IDLE.

Top module: `phy_cport_master`

## Requirements
- R1: After reset, cmd_ready is 1 and all four strobes, done, done_err and err_sticky are 0.
- R2: Opcode 0 (address) places cmd_data on phy_din. It raises phy_cap_addr, lowers it once acknowledge is seen high, and ends with done once acknowledge is seen low. No two strobes are ever high together, and phy_din holds steady while a command is in progress.
- R3: Opcode 1 (write) with data bit 0 clear runs a full phy_cap_data handshake, then a full phy_wr handshake, and ends with done_err 0.
- R4: Opcode 1 with data bit 0 set runs the phy_cap_data handshake, then raises phy_wr and signals done in that same step without waiting for acknowledge. phy_wr stays high until the next command is taken.
- R5: Opcode 2 or 3 (read) raises phy_rd. It latches phy_dout into rd_data on the poll that sees acknowledge high, then completes the low phase. rd_data holds its value through non-read commands.
- R6: Each wait samples acknowledge on its first cycle and then every POLL_CYC = CLK_MHZ*POLL_US cycles, for at most MAX_POLLS samples. With acknowledge trailing the strobes by one cycle, an address command signals done 2*POLL_CYC+3 cycles after the accepting edge. If acknowledge is stuck high, done follows the accepting edge after 9*POLL_CYC+3 cycles, with done_err set (MAX_POLLS=10).
- R7: On timeout, done is pulsed with done_err 1 and the strobe is left at its current level. err_sticky rises and stays high until reset. Later commands that complete report done_err 0.
- R8: cmd_ready is low from the accepting edge until done has been pulsed. done is a single-cycle pulse, and each accepted command produces exactly one done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and taking a command |
| cmd_op | input | 2 | 0 address, 1 write, 2/3 read |
| cmd_data | input | 16 | Address or write value |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion ended in timeout (valid with done) |
| rd_data | output | 16 | Word latched by the last read |
| err_sticky | output | 1 | Set by any timeout, cleared by reset |
| phy_din | output | 16 | PHY control data-in bus |
| phy_cap_addr | output | 1 | Address capture strobe |
| phy_cap_data | output | 1 | Data capture strobe |
| phy_wr | output | 1 | Write strobe |
| phy_rd | output | 1 | Read strobe |
| phy_ack | input | 1 | PHY acknowledge |
| phy_dout | input | 16 | PHY control data-out bus |

## Verification
Counting from the edge that takes a command, the strobe of the first phase rises two edges later, after the SETUP step. A handshake against an acknowledge that trails by one cycle finishes each phase one poll interval after its first sample. Hence done after 2*POLL_CYC+3 edges for address and read commands. A dead acknowledge gives 9*POLL_CYC+2 edges, and a stuck-high acknowledge gives 9*POLL_CYC+3. A scoreboard receives one expected record per command. A monitor counts falling edges from acceptance, strobe rises and ready violations. When done appears, it compares the latency, done_err, rd_data, phy_din, err_sticky and the strobe levels left behind.

// File: rtl/cport_pkg.sv
package cport_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DCAP_HI,
        ST_DCAP_LO,
        ST_WR_HI,
        ST_WR_LO,
        ST_RD_HI,
        ST_RD_LO,
        ST_DONE
    } cport_state_e;

    localparam int NUM_SB  = 4;
    localparam int SB_ADDR = 0;
    localparam int SB_DCAP = 1;
    localparam int SB_WR   = 2;
    localparam int SB_RD   = 3;

    function automatic logic st_is_hi(cport_state_e s);
        return (s == ST_ADDR_HI) || (s == ST_DCAP_HI) ||
               (s == ST_WR_HI)   || (s == ST_RD_HI);
    endfunction

    function automatic logic st_is_lo(cport_state_e s);
        return (s == ST_ADDR_LO) || (s == ST_DCAP_LO) ||
               (s == ST_WR_LO)   || (s == ST_RD_LO);
    endfunction

    function automatic logic [1:0] st_strobe(cport_state_e s);
        logic [1:0] idx;
        case (s)
            ST_DCAP_HI, ST_DCAP_LO: idx = 2'(SB_DCAP);
            ST_WR_HI,   ST_WR_LO:   idx = 2'(SB_WR);
            ST_RD_HI,   ST_RD_LO:   idx = 2'(SB_RD);
            default:                idx = 2'(SB_ADDR);
        endcase
        return idx;
    endfunction

endpackage

// File: rtl/cport_poll_timer.sv
module cport_poll_timer #(
    parameter int POLL_CYC  = 25000,
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic active,
    output logic sample,
    output logic last
);
    localparam int CW = (POLL_CYC  > 1) ? $clog2(POLL_CYC)  : 1;
    localparam int PW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    logic [CW-1:0] gap_q;
    logic [PW-1:0] polls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (restart) begin
            gap_q   <= '0;
            polls_q <= '0;
        end else if (active) begin
            if (gap_q == '0) begin
                gap_q <= CW'(POLL_CYC - 1);
                if (polls_q != PW'(MAX_POLLS - 1))
                    polls_q <= polls_q + 1'b1;
            end else begin
                gap_q <= gap_q - 1'b1;
            end
        end
    end

    assign sample = active && (gap_q == '0);
    assign last   = (polls_q == PW'(MAX_POLLS - 1));

endmodule

// File: rtl/cport_strobe_bank.sv
module cport_strobe_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_all,
    input  logic [N-1:0] set_v,
    input  logic [N-1:0] drop_v,
    output logic [N-1:0] strobe
);
    for (genvar i = 0; i < N; i++) begin : g_sb
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         strobe[i] <= 1'b0;
            else if (clr_all)   strobe[i] <= 1'b0;
            else if (set_v[i])  strobe[i] <= 1'b1;
            else if (drop_v[i]) strobe[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/phy_cport_master.sv
module phy_cport_master
    import cport_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CLK_MHZ   = 250,
    parameter int POLL_US   = 100,
    parameter int MAX_POLLS = 10,
    parameter int RST_BIT   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [1:0]    cmd_op,
    input  logic [DW-1:0] cmd_data,
    output logic          done,
    output logic          done_err,
    output logic [DW-1:0] rd_data,
    output logic          err_sticky,
    output logic [DW-1:0] phy_din,
    output logic          phy_cap_addr,
    output logic          phy_cap_data,
    output logic          phy_wr,
    output logic          phy_rd,
    input  logic          phy_ack,
    input  logic [DW-1:0] phy_dout
);
    localparam int POLL_CYC = CLK_MHZ * POLL_US;

    cport_state_e state_q, state_d;

    logic [1:0]        op_q;
    logic [DW-1:0]     din_q;
    logic [DW-1:0]     rd_q;
    logic              res_err_q;
    logic              sticky_q;
    logic              accept;
    logic              in_wait;
    logic              exp_lvl;
    logic              sample;
    logic              last;
    logic              pass;
    logic              miss_final;
    logic              restart;
    logic              tmo;
    logic              rst_wr;
    logic              cap_rd;
    logic [NUM_SB-1:0] set_v;
    logic [NUM_SB-1:0] drop_v;
    logic [NUM_SB-1:0] sb;

    assign accept     = (state_q == ST_IDLE) && cmd_valid;
    assign in_wait    = st_is_hi(state_q) || st_is_lo(state_q);
    assign exp_lvl    = st_is_hi(state_q);
    assign pass       = sample && (phy_ack == exp_lvl);
    assign miss_final = sample && (phy_ack != exp_lvl) && last;
    assign restart    = (state_d != state_q);

    cport_poll_timer #(
        .POLL_CYC  (POLL_CYC),
        .MAX_POLLS (MAX_POLLS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .active  (in_wait),
        .sample  (sample),
        .last    (last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        rst_wr  = 1'b0;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_SETUP;
            ST_SETUP: begin
                if (op_q[1])      state_d = ST_RD_HI;
                else if (op_q[0]) state_d = ST_DCAP_HI;
                else              state_d = ST_ADDR_HI;
            end
            ST_ADDR_HI: if (pass) state_d = ST_ADDR_LO;
            ST_ADDR_LO: if (pass) state_d = ST_DONE;
            ST_DCAP_HI: if (pass) state_d = ST_DCAP_LO;
            ST_DCAP_LO: begin
                if (pass) begin
                    if (din_q[RST_BIT]) begin
                        state_d = ST_DONE;
                        rst_wr  = 1'b1;
                    end else begin
                        state_d = ST_WR_HI;
                    end
                end
            end
            ST_WR_HI:   if (pass) state_d = ST_WR_LO;
            ST_WR_LO:   if (pass) state_d = ST_DONE;
            ST_RD_HI:   if (pass) state_d = ST_RD_LO;
            ST_RD_LO:   if (pass) state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (in_wait && miss_final) state_d = ST_DONE;
    end

    assign tmo    = in_wait && miss_final;
    assign cap_rd = (state_q == ST_RD_HI) && pass;

    for (genvar i = 0; i < NUM_SB; i++) begin : g_edge
        assign set_v[i]  = (restart && st_is_hi(state_d) && (st_strobe(state_d) == 2'(i)))
                           || ((i == SB_WR) && rst_wr);
        assign drop_v[i] = restart && st_is_lo(state_d) && (st_strobe(state_d) == 2'(i));
    end

    cport_strobe_bank #(
        .N (NUM_SB)
    ) u_strobes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (accept),
        .set_v   (set_v),
        .drop_v  (drop_v),
        .strobe  (sb)
    );

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= '0;
            din_q     <= '0;
            rd_q      <= '0;
            res_err_q <= 1'b0;
            sticky_q  <= 1'b0;
        end else begin
            if (accept) begin
                op_q      <= cmd_op;
                din_q     <= cmd_data;
                res_err_q <= 1'b0;
            end
            if (cap_rd) rd_q <= phy_dout;
            if (tmo) begin
                res_err_q <= 1'b1;
                sticky_q  <= 1'b1;
            end
        end
    end

    assign cmd_ready    = (state_q == ST_IDLE);
    assign done         = (state_q == ST_DONE);
    assign done_err     = res_err_q;
    assign rd_data      = rd_q;
    assign err_sticky   = sticky_q;
    assign phy_din      = din_q;
    assign phy_cap_addr = sb[SB_ADDR];
    assign phy_cap_data = sb[SB_DCAP];
    assign phy_wr       = sb[SB_WR];
    assign phy_rd       = sb[SB_RD];

endmodule

// File: rtl/cport_master_chk.sv
module cport_master_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          done,
    input logic          done_err,
    input logic          err_sticky,
    input logic [DW-1:0] phy_din,
    input logic          phy_cap_addr,
    input logic          phy_cap_data,
    input logic          phy_wr,
    input logic          phy_rd
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_cap_addr, phy_cap_data, phy_wr, phy_rd}));

    p_din_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && $past(!cmd_ready)) |-> $stable(phy_din));

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    p_done_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !cmd_ready);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_err_sets_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> err_sticky);

endmodule

bind phy_cport_master cport_master_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .done         (done),
    .done_err     (done_err),
    .err_sticky   (err_sticky),
    .phy_din      (phy_din),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_wr       (phy_wr),
    .phy_rd       (phy_rd)
);

// File: tb/phy_cport_master_test.sv
module phy_cport_master_test;
    localparam int CLK_MHZ = 1;
    localparam int POLL_US = 4;
    localparam int P       = CLK_MHZ * POLL_US;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = 16'h0;
    logic        done, done_err, err_sticky;
    logic [15:0] rd_data, phy_din;
    logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd;
    logic        phy_ack;
    logic [15:0] phy_dout = 16'h0;
    logic [1:0]  ack_mode = 2'd0;
    logic [3:0]  sb;

    always #2 clk = ~clk;

    phy_cport_master #(.CLK_MHZ(CLK_MHZ), .POLL_US(POLL_US)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .done_err(done_err),
        .rd_data(rd_data), .err_sticky(err_sticky), .phy_din(phy_din),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack), .phy_dout(phy_dout)
    );

    assign sb = {phy_rd, phy_wr, phy_cap_data, phy_cap_addr};

    // PHY responder: 0 follows strobes one cycle late, 1 silent, 2 stuck high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                phy_ack <= 1'b0;
        else if (ack_mode == 2'd0) phy_ack <= |sb;
        else if (ack_mode == 2'd1) phy_ack <= 1'b0;
        else                       phy_ack <= 1'b1;
    end

    typedef struct {
        string       req;
        logic        err;
        logic        chk_rd;
        logic [15:0] rd;
        int          lat;
        logic [15:0] rises;
        logic [3:0]  lvl;
        logic [15:0] din;
        logic        sticky;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    bit          finished = 0;
    bit          busy = 0;
    bit          ready_bad = 0;
    int          cyc = 0;
    logic [15:0] rises = '0;
    logic [3:0]  prev_sb = '0;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t mk(string req, logic err, logic chk_rd, logic [15:0] rd, int lat,
                                logic [15:0] rs, logic [3:0] lvl, logic [15:0] din, logic sticky);
        exp_t e;
        e.req = req; e.err = err; e.chk_rd = chk_rd; e.rd = rd; e.lat = lat;
        e.rises = rs; e.lvl = lvl; e.din = din; e.sticky = sticky;
        return e;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) begin
                cyc++;
                for (int i = 0; i < 4; i++)
                    if (sb[i] && !prev_sb[i]) rises[i*4 +: 4] = rises[i*4 +: 4] + 4'd1;
                prev_sb = sb;
                if (done) begin
                    busy = 0;
                    if (sbq.size() == 0) begin
                        check(0, "R8", "done without command", 1, 0);
                    end else begin
                        cur = sbq.pop_front();
                        check(done_err == cur.err, cur.req, "done_err", 32'(done_err), 32'(cur.err));
                        if (cur.chk_rd)
                            check(rd_data == cur.rd, cur.req, "rd_data", 32'(rd_data), 32'(cur.rd));
                        if (cur.lat >= 0)
                            check(cyc == cur.lat, "R6", "latency", 32'(cyc), 32'(cur.lat));
                        check(rises == cur.rises, cur.req, "strobe rises", 32'(rises), 32'(cur.rises));
                        check(sb == cur.lvl, cur.req, "strobe levels", 32'(sb), 32'(cur.lvl));
                        check(phy_din == cur.din, "R2", "phy_din", 32'(phy_din), 32'(cur.din));
                        check(err_sticky == cur.sticky, "R7", "err_sticky", 32'(err_sticky), 32'(cur.sticky));
                        check(!ready_bad, "R8", "ready low while busy", 32'(ready_bad), 0);
                    end
                end else if (cmd_ready) begin
                    ready_bad = 1;
                end
            end else if (cmd_valid && cmd_ready) begin
                busy = 1; cyc = 0; rises = '0; prev_sb = sb; ready_bad = 0;
            end
        end
    end

    task automatic send(logic [1:0] op, logic [15:0] d, exp_t e);
        @(posedge clk); #1;
        while (!cmd_ready) begin @(posedge clk); #1; end
        sbq.push_back(e);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(posedge clk); #1;
        while (!(cmd_ready && !busy && sbq.size() == 0)) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL R8 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cmd_ready == 1'b1, "R1", "ready in reset", 32'(cmd_ready), 1);
        check(sb == 4'b0, "R1", "strobes in reset", 32'(sb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !done_err && !err_sticky, "R1", "flags after reset",
              32'({done, done_err, err_sticky}), 0);
        check(cmd_ready == 1'b1, "R1", "ready after reset", 32'(cmd_ready), 1);

        // R2: address handshake, exact latency
        send(2'd0, 16'h2003, mk("R2", 0, 0, 0, 2*P+4, 16'h0001, 4'b0000, 16'h2003, 0));
        // R3: full write
        send(2'd1, 16'h1234, mk("R3", 0, 0, 0, -1, 16'h0110, 4'b0000, 16'h1234, 0));
        wait_idle();
        // R5: read
        phy_dout = 16'hBEEF;
        send(2'd2, 16'h0010, mk("R5", 0, 1, 16'hBEEF, 2*P+4, 16'h1000, 4'b0000, 16'h0010, 0));
        wait_idle();
        phy_dout = 16'h0000;
        // R4: reset-bit write leaves write strobe high
        send(2'd1, 16'h0001, mk("R4", 0, 0, 0, -1, 16'h0110, 4'b0100, 16'h0001, 0));
        wait_idle();
        check(rd_data == 16'hBEEF, "R5", "rd_data held", 32'(rd_data), 32'hBEEF);
        check(phy_wr == 1'b1, "R4", "write strobe kept", 32'(phy_wr), 1);
        // R5: opcode 3 reads, and clears the leftover write strobe
        phy_dout = 16'h5A5A;
        send(2'd3, 16'h0000, mk("R5", 0, 1, 16'h5A5A, -1, 16'h1000, 4'b0000, 16'h0000, 0));
        wait_idle();
        // R7: silent PHY, timeout in high phase
        ack_mode = 2'd1;
        send(2'd0, 16'h00E0, mk("R7", 1, 0, 0, 9*P+3, 16'h0001, 4'b0001, 16'h00E0, 1));
        wait_idle();
        // R7: later good command, sticky held
        ack_mode = 2'd0;
        send(2'd1, 16'h0002, mk("R7", 0, 0, 0, -1, 16'h0110, 4'b0000, 16'h0002, 1));
        wait_idle();
        // R6: acknowledge stuck high, timeout in low phase
        ack_mode = 2'd2;
        send(2'd0, 16'h7F3F, mk("R6", 1, 0, 0, 9*P+4, 16'h0001, 4'b0000, 16'h7F3F, 1));
        wait_idle();
        check(err_sticky == 1'b1, "R7", "sticky at end", 32'(err_sticky), 1);
        finish_run();
    end

endmodule